// File: doc/BRIEF.md
# Serial Divider-Word Loader With Destination Tag

This block takes a three-wire serial stream (bit clock, bit data and a load strobe) and turns it into the static settings of a frequency synthesizer. Each bit-clock rising edge pushes one data bit into a 19-bit shift register, with the first bit sent ending up in the most significant position. When the load strobe goes high, the final bit that was shifted in works as a destination tag. A tag of 1 routes the word to the reference settings. Those are a 14-bit reference divide value, a prescaler-modulus select, a phase-polarity select and a monitor-output select. A tag of 0 routes the word to the feedback settings. Those are a 7-bit swallow count and an 11-bit main count.

All inputs are sampled on the system clock `clk`. The bit clock is edge-detected in that domain. A small state machine runs the strobe. Its states are WAIT_LOW, ARMED, LOAD_REF, LOAD_FB and DROP:
- WAIT_LOW goes to ARMED when the strobe is low.
- ARMED goes to LOAD_REF when the strobe is high, the tag is 1 and the reference value is legal.
- ARMED goes to DROP when the strobe is high, the tag is 1 and the reference value is below the minimum.
- ARMED goes to LOAD_FB when the strobe is high and the tag is 0.
- LOAD_REF, LOAD_FB and DROP each return to WAIT_LOW after one cycle.

Reset enters WAIT_LOW, so a strobe that is held high through reset causes no copy. Shifting continues in every state. Nothing in the block depends on a power-down condition, so words can be loaded while the rest of the synthesizer sleeps.

Top module: `synth_serial_loader`

## Requirements
- R1: Each rising edge of `sclk` (as sampled by `clk`) shifts `sdata` into bit 0 of the shift register and moves every other bit up one position. Bit positions below count from 0, which is the last bit shifted.
- R2: On a strobe, a tag (position 0) of 1 updates only the reference outputs, and a tag of 0 updates only the feedback outputs. The other bank keeps its value.
- R3: Feedback word layout: `swallow` comes from positions 7..1 and `main_div` from positions 18..8. In each field the higher position is the more significant bit.
- R4: Reference word layout: `ref_div` comes from positions 14..1, `pre_sel` from 15, `pol_sel` from 16 and `mon_sel` from 17. Position 18 has no effect, so an 18-bit word sent after any earlier traffic loads the same values.
- R5: After reset the outputs are `ref_div`=5, `pre_sel`=0, `pol_sel`=1, `mon_sel`=0 (lock-detect selected), `swallow`=0 and `main_div`=5.
- R6: Exactly one copy happens per strobe assertion. The transfer does not clear the shift register, so a second strobe with no new bits reloads the same word.
- R7: The outputs change on the second `clk` edge that samples `le` high, and not on the first. They do not change while `le` stays high, even if new bits are shifted in.
- R8: A reference word whose divide value is below 5 is dropped, and the reference outputs keep their previous values. A value of exactly 5 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock, shifts on its rising edge |
| sdata | input | 1 | Serial data bit |
| le | input | 1 | Load strobe, copies the word while high (once per assertion) |
| ref_div | output | 14 | Reference divide value |
| pre_sel | output | 1 | Prescaler modulus select |
| pol_sel | output | 1 | Phase comparator polarity select |
| mon_sel | output | 1 | Monitor output select, 0 selects lock detect |
| swallow | output | 7 | Swallow count |
| main_div | output | 11 | Main count |

## Verification
The bench checks the exact bit positions of every field, both with a full 19-bit reference word whose top bit is 1 and with a bare 18-bit word. A design that sliced the fields one position off, or that decoded the ignored top bit, would show wrong values. It loads a reference word with divide values 4 and 0 and checks that both are refused, then checks that 5 is accepted. A design with an off-by-one limit, or one that latched anyway, would change `ref_div`. It probes the output on the first and second clock after the strobe rises, and shifts new bits while the strobe is held. It then re-strobes with no new bits, which exposes a design that copies twice, copies early or late, or clears the shift register on a transfer (that last one would reload zeros).

// File: rtl/loader_pkg.sv
package loader_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_LOW = 3'd0,
        ST_ARMED    = 3'd1,
        ST_LOAD_REF = 3'd2,
        ST_LOAD_FB  = 3'd3,
        ST_DROP     = 3'd4
    } load_state_t;

    localparam int DEF_R_W   = 14;
    localparam int DEF_A_W   = 7;
    localparam int DEF_N_W   = 11;
    localparam int DEF_R_MIN = 5;

endpackage

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int SR_W = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdata_i,
    output logic [SR_W-1:0] sr_o
);

    logic            sclk_q;
    logic            rise;
    logic [SR_W-1:0] sr_q;

    assign rise = sclk_i & ~sclk_q;
    assign sr_o = sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (rise) begin
            sr_q <= {sr_q[SR_W-2:0], sdata_i};
        end
    end

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sr_q)); // R1

endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import loader_pkg::*;
#(
    parameter int R_W   = 14,
    parameter int R_MIN = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           le_i,
    input  logic           tag_i,
    input  logic [R_W-1:0] rcand_i,
    output logic           ld_ref_o,
    output logic           ld_fb_o
);

    localparam logic [R_W-1:0] R_MIN_V = R_W'(R_MIN);

    load_state_t state_q, state_d;
    logic        legal;

    assign legal = (rcand_i >= R_MIN_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_LOW: begin
                if (!le_i) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (le_i) begin
                    if (!tag_i) begin
                        state_d = ST_LOAD_FB;
                    end else if (legal) begin
                        state_d = ST_LOAD_REF;
                    end else begin
                        state_d = ST_DROP;
                    end
                end
            end
            ST_LOAD_REF: state_d = ST_WAIT_LOW;
            ST_LOAD_FB:  state_d = ST_WAIT_LOW;
            ST_DROP:     state_d = ST_WAIT_LOW;
            default:     state_d = ST_WAIT_LOW;
        endcase
    end

    always_comb begin
        ld_ref_o = 1'b0;
        ld_fb_o  = 1'b0;
        unique case (state_q)
            ST_LOAD_REF: ld_ref_o = 1'b1;
            ST_LOAD_FB:  ld_fb_o  = 1'b1;
            default: begin
                ld_ref_o = 1'b0;
                ld_fb_o  = 1'b0;
            end
        endcase
    end

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_ref_o, ld_fb_o})); // R2
    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ref_o || ld_fb_o) |=> !(ld_ref_o || ld_fb_o)); // R6
    AST_COPY_AFTER_LE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ref_o || ld_fb_o) |-> $past(le_i)); // R7

endmodule

// File: rtl/ref_bank.sv
module ref_bank #(
    parameter int R_W   = 14,
    parameter int R_MIN = 5,
    parameter int R_RST = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [R_W+2:0] word_i,
    output logic [R_W-1:0] r_o,
    output logic           sw_o,
    output logic           fc_o,
    output logic           lds_o
);

    localparam logic [R_W-1:0] R_RST_V = R_W'(R_RST);
    localparam logic [R_W-1:0] R_MIN_V = R_W'(R_MIN);

    logic [R_W-1:0] r_q;
    logic           sw_q, fc_q, lds_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= R_RST_V;
            sw_q  <= 1'b0;
            fc_q  <= 1'b1;
            lds_q <= 1'b0;
        end else if (load_i) begin
            r_q   <= word_i[R_W-1:0];
            sw_q  <= word_i[R_W];
            fc_q  <= word_i[R_W+1];
            lds_q <= word_i[R_W+2];
        end
    end

    assign r_o   = r_q;
    assign sw_o  = sw_q;
    assign fc_o  = fc_q;
    assign lds_o = lds_q;

    AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        r_q >= R_MIN_V); // R8
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable({r_q, sw_q, fc_q, lds_q})); // R2

endmodule

// File: rtl/fb_bank.sv
module fb_bank #(
    parameter int A_W   = 7,
    parameter int N_W   = 11,
    parameter int N_RST = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [A_W+N_W-1:0] word_i,
    output logic [A_W-1:0]     a_o,
    output logic [N_W-1:0]     n_o
);

    localparam logic [N_W-1:0] N_RST_V = N_W'(N_RST);

    logic [A_W-1:0] a_q;
    logic [N_W-1:0] n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            n_q <= N_RST_V;
        end else if (load_i) begin
            a_q <= word_i[A_W-1:0];
            n_q <= word_i[A_W+N_W-1:A_W];
        end
    end

    assign a_o = a_q;
    assign n_o = n_q;

    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable({a_q, n_q})); // R2

endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
    import loader_pkg::*;
#(
    parameter int R_W   = DEF_R_W,
    parameter int A_W   = DEF_A_W,
    parameter int N_W   = DEF_N_W,
    parameter int R_MIN = DEF_R_MIN,
    parameter int R_RST = 5,
    parameter int N_RST = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdata,
    input  logic           le,
    output logic [R_W-1:0] ref_div,
    output logic           pre_sel,
    output logic           pol_sel,
    output logic           mon_sel,
    output logic [A_W-1:0] swallow,
    output logic [N_W-1:0] main_div
);

    localparam int FB_W  = A_W + N_W;
    localparam int REF_W = R_W + 3;
    localparam int SR_W  = (FB_W > REF_W) ? FB_W + 1 : REF_W + 1;

    logic [SR_W-1:0] sr;
    logic            ld_ref, ld_fb;

    ser_shift #(.SR_W(SR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .sdata_i (sdata),
        .sr_o    (sr)
    );

    load_ctrl #(.R_W(R_W), .R_MIN(R_MIN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .le_i     (le),
        .tag_i    (sr[0]),
        .rcand_i  (sr[R_W:1]),
        .ld_ref_o (ld_ref),
        .ld_fb_o  (ld_fb)
    );

    ref_bank #(.R_W(R_W), .R_MIN(R_MIN), .R_RST(R_RST)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld_ref),
        .word_i (sr[REF_W:1]),
        .r_o    (ref_div),
        .sw_o   (pre_sel),
        .fc_o   (pol_sel),
        .lds_o  (mon_sel)
    );

    fb_bank #(.A_W(A_W), .N_W(N_W), .N_RST(N_RST)) u_fb (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld_fb),
        .word_i (sr[FB_W:1]),
        .a_o    (swallow),
        .n_o    (main_div)
    );

endmodule

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        le = 1'b0;
    logic [13:0] ref_div;
    logic        pre_sel, pol_sel, mon_sel;
    logic [6:0]  swallow;
    logic [10:0] main_div;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .le(le),
        .ref_div(ref_div), .pre_sel(pre_sel), .pol_sel(pol_sel), .mon_sel(mon_sel),
        .swallow(swallow), .main_div(main_div)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [18:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            sdata = w[i];
            sclk  = 1'b0;
            @(negedge clk);
            sclk  = 1'b1;
        end
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk);
        le = 1'b1;
        repeat (4) @(negedge clk);
        le = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [18:0] fb_word(input int a, input int n);
        return {n[10:0], a[6:0], 1'b0};
    endfunction

    function automatic logic [18:0] ref_word(input logic top, input int r,
                                             input logic sw, input logic fc, input logic lds);
        return {top, lds, fc, sw, r[13:0], 1'b1};
    endfunction

    task automatic check_ref(input string req, input int r, input int sw, input int fc, input int lds);
        check({req, " ref_div"}, int'(ref_div), r);
        check({req, " pre_sel"}, int'(pre_sel), sw);
        check({req, " pol_sel"}, int'(pol_sel), fc);
        check({req, " mon_sel"}, int'(mon_sel), lds);
    endtask

    task automatic check_fb(input string req, input int a, input int n);
        check({req, " swallow"}, int'(swallow), a);
        check({req, " main_div"}, int'(main_div), n);
    endtask

    task automatic t_reset();
        check_ref("R5", 5, 0, 1, 0);
        check_fb("R5", 0, 5);
    endtask

    task automatic t_fb_load();
        send_bits(fb_word(93, 1234), 19);
        strobe();
        check_fb("R3", 93, 1234);
        check_ref("R2 ref untouched", 5, 0, 1, 0);
        send_bits(fb_word(127, 2047), 19);
        strobe();
        check_fb("R1 R3 all ones", 127, 2047);
    endtask

    task automatic t_ref_load();
        send_bits(ref_word(1'b1, 9876, 1'b1, 1'b0, 1'b1), 19);
        strobe();
        check_ref("R4", 9876, 1, 0, 1);
        check_fb("R2 fb untouched", 127, 2047);
        send_bits(ref_word(1'b0, 16383, 1'b0, 1'b1, 1'b0), 18);
        strobe();
        check_ref("R4 18-bit word", 16383, 0, 1, 0);
    endtask

    task automatic t_reject();
        send_bits(ref_word(1'b0, 4, 1'b1, 1'b0, 1'b1), 19);
        strobe();
        check_ref("R8 value 4 dropped", 16383, 0, 1, 0);
        send_bits(ref_word(1'b1, 0, 1'b1, 1'b1, 1'b1), 19);
        strobe();
        check_ref("R8 value 0 dropped", 16383, 0, 1, 0);
        send_bits(ref_word(1'b0, 5, 1'b1, 1'b1, 1'b1), 19);
        strobe();
        check_ref("R8 value 5 accepted", 5, 1, 1, 1);
    endtask

    task automatic t_timing();
        send_bits(fb_word(17, 300), 19);
        @(negedge clk);
        le = 1'b1;
        @(negedge clk);
        check("R7 first edge no change", int'(main_div), 2047);
        @(negedge clk);
        check("R7 second edge updates", int'(main_div), 300);
        send_bits(fb_word(44, 777), 19);
        check_fb("R7 held while le high", 17, 300);
        le = 1'b0;
        repeat (3) @(negedge clk);
        check_fb("R6 no copy on fall", 17, 300);
        strobe();
        check_fb("R6 next strobe copies", 44, 777);
    endtask

    task automatic t_reuse();
        strobe();
        check_fb("R6 register not cleared", 44, 777);
        check_ref("R6 ref unaffected", 5, 1, 1, 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_fb_load();
        t_ref_load();
        t_reject();
        t_timing();
        t_reuse();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule